// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Collector

This block gathers three single-cycle event pulses (periodic tick, alarm match, update complete) into sticky flags. A small enable register masks each flag onto a shared, active-low interrupt line. The line is modelled as an open-drain pad: the data pin is always 0 and the enable pin is asserted whenever any enabled flag is set. Software reads a status byte through a level read strobe. The byte holds the summary request bit and the three flags. It is captured when the strobe is first sampled high and held unchanged until the strobe drops.

The flags captured in the byte are cleared when the strobe falls. An event that lands while a status read is open is parked in a per-flag pending slot and posted when the read closes. A second read address returns a fixed "contents valid" byte and has no side effects.

The read port has no back-pressure. The strobe is a plain level and the data is valid from the cycle after the first high sample until the strobe drops. Events and configuration writes are plain single-cycle pulses that are always accepted.

Top module: `evt_irq_status`

## Requirements
- R1: After reset all flags, all enables, `irq_oe` and `rd_data` are 0.
- R2: A pulse on an event input sets its flag on that clock edge whatever its enable is. The flag stays set until a status read clears it.
- R3: `irq_oe` is 1 exactly when at least one flag and its enable are both 1, and `irq_o` is always 0. If an enable is written to 1 while its flag is already set, `irq_oe` rises on the cycle after the write.
- R4: A status read (`rd_sel`=0) returns bit 7 = request summary, bit 6 = periodic flag, bit 5 = alarm flag, bit 4 = update flag, and bits 3..0 = 0. All of these are the values held just before the edge at which the strobe is first sampled high.
- R5: While a status read is open, `rd_data` and `irq_oe` do not change because of events.
- R6: At the edge where the strobe is first sampled low after a status read, every captured flag is cleared. A following read with no new events returns 0x00.
- R7: An event pulse that arrives from the first high sample of the strobe through the first low sample is set in its flag right after the read closes.
- R8: A configuration write with `cfg_set`=1 leaves the update enable at 0, whatever value `cfg_uie` has.
- R9: A read with `rd_sel`=1 returns 0x80, and neither clears nor defers any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_periodic | input | 1 | Periodic tick event pulse |
| evt_alarm | input | 1 | Alarm match event pulse |
| evt_update | input | 1 | Update-complete event pulse |
| cfg_wr | input | 1 | Configuration write pulse |
| cfg_set | input | 1 | Hold-time-setting bit; when 1 the update enable is forced to 0 |
| cfg_pie | input | 1 | Periodic enable value written |
| cfg_aie | input | 1 | Alarm enable value written |
| cfg_uie | input | 1 | Update enable value written |
| rd_strobe | input | 1 | Read strobe, high for the whole read |
| rd_sel | input | 1 | Read address: 0 status byte, 1 valid byte |
| rd_data | output | 8 | Captured read byte |
| irq_o | output | 1 | Interrupt pad data, constant 0 |
| irq_oe | output | 1 | Interrupt pad drive enable, 1 = line pulled low |

## Verification
The bench drives events in the capture cycle, in the middle of a read and in the cycle where the strobe falls. A design that lost those events, or posted them early, would show a changed byte mid-read, a spurious interrupt edge, or an empty byte on the following read. It writes an enable while its flag is already pending, and writes the set bit together with an update enable. A design that only reacted to new events, or let the set bit be ignored, would leave the line wrong. It mixes valid-byte reads with status reads, so a design that cleared or parked flags on the wrong address shows missing or late flags. Long random runs with overlapping events, writes and reads of varied length compare every cycle against a bench-side model.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  localparam int NSRC   = 3;
  localparam int BYTE_W = 8;
  // flag vector index: also the order of the bits below the summary bit
  localparam int SRC_UPD = 0;
  localparam int SRC_ALM = 1;
  localparam int SRC_PER = 2;
  localparam logic [BYTE_W-1:0] VALID_BYTE = 8'h80;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irqs_flag_cell.sv
module irqs_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic capture,
  input  logic hold,
  input  logic release_i,
  output logic flag_o
);
  logic flag_q;
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (release_i) begin
      flag_q <= pend_q | evt;
      pend_q <= 1'b0;
    end else if (capture || hold) begin
      pend_q <= pend_q | evt;
    end else begin
      flag_q <= flag_q | evt;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irqs_enable_reg.sv
module irqs_enable_reg
  import irqs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  logic     set_mode,
  input  logic     pie,
  input  logic     aie,
  input  logic     uie,
  output src_vec_t en_o
);
  src_vec_t en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr) begin
      en_q[SRC_PER] <= pie;
      en_q[SRC_ALM] <= aie;
      en_q[SRC_UPD] <= uie & ~set_mode;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/irqs_read_port.sv
module irqs_read_port
  import irqs_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              sel,
  input  src_vec_t          flags,
  input  logic              irqf,
  output logic              capture_o,
  output logic              hold_o,
  output logic              release_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int PAD_W = DATA_W - 1 - NSRC;

  logic              strobe_q;
  logic              hold_q;
  logic [DATA_W-1:0] data_q;
  logic              rise;

  assign rise      = strobe & ~strobe_q;
  assign capture_o = rise & ~sel;
  assign release_o = ~strobe & hold_q;
  assign hold_o    = hold_q;
  assign data_o    = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      hold_q   <= 1'b0;
      data_q   <= '0;
    end else begin
      strobe_q <= strobe;
      if (capture_o)   hold_q <= 1'b1;
      else if (!strobe) hold_q <= 1'b0;
      if (rise) begin
        if (sel) data_q <= DATA_W'(VALID_BYTE);
        else     data_q <= {irqf, flags, {PAD_W{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status
  import irqs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_periodic,
  input  logic              evt_alarm,
  input  logic              evt_update,
  input  logic              cfg_wr,
  input  logic              cfg_set,
  input  logic              cfg_pie,
  input  logic              cfg_aie,
  input  logic              cfg_uie,
  input  logic              rd_strobe,
  input  logic              rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  output logic              irq_o,
  output logic              irq_oe
);
  src_vec_t evt_vec;
  src_vec_t flags;
  src_vec_t en;
  logic     read_capture;
  logic     read_hold;
  logic     read_release;
  logic     irqf;

  assign evt_vec[SRC_PER] = evt_periodic;
  assign evt_vec[SRC_ALM] = evt_alarm;
  assign evt_vec[SRC_UPD] = evt_update;

  irqs_enable_reg i_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .set_mode (cfg_set),
    .pie      (cfg_pie),
    .aie      (cfg_aie),
    .uie      (cfg_uie),
    .en_o     (en)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    irqs_flag_cell i_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt_vec[g]),
      .capture   (read_capture),
      .hold      (read_hold),
      .release_i (read_release),
      .flag_o    (flags[g])
    );
  end

  assign irqf = |(flags & en);

  irqs_read_port #(.DATA_W(BYTE_W)) i_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (rd_strobe),
    .sel       (rd_sel),
    .flags     (flags),
    .irqf      (irqf),
    .capture_o (read_capture),
    .hold_o    (read_hold),
    .release_o (read_release),
    .data_o    (rd_data)
  );

  assign irq_oe = irqf;
  assign irq_o  = 1'b0;
endmodule

// File: rtl/evt_irq_status_chk.sv
module evt_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_periodic,
  input logic       evt_alarm,
  input logic       evt_update,
  input logic       cfg_wr,
  input logic       rd_strobe,
  input logic       rd_sel,
  input logic [7:0] rd_data,
  input logic       irq_oe,
  input logic       read_hold,
  input logic       read_release
);
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_oe) |-> ($past(cfg_wr) || $past(evt_periodic | evt_alarm | evt_update)
                       || ($past(!rd_strobe) && $past(rd_strobe, 2)))); // R3

  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_oe) |-> ($past(cfg_wr) || ($past(!rd_strobe) && $past(rd_strobe, 2)))); // R6

  AST_IRQ_HELD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (read_hold && !read_release && !cfg_wr) |=> $stable(irq_oe)); // R5

  AST_DATA_HELD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (read_hold && rd_strobe) |=> $stable(rd_data)); // R5

  AST_VALID_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_strobe) && !$past(rd_strobe, 2) && $past(rd_sel)) |-> (rd_data == 8'h80)); // R9
endmodule

bind evt_irq_status evt_irq_status_chk i_chk (.*);

// File: tb/test_evt_irq_status.sv
module test_evt_irq_status;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] ev;          // [2] periodic, [1] alarm, [0] update
  logic       wr, set_b, pie, aie, uie;
  logic       st, sel;
  logic [7:0] rd_data;
  logic       irq_o, irq_oe;

  int n_cmp  = 0;
  int n_fail = 0;

  // bench model
  logic [2:0] m_flag, m_pend, m_en;
  logic [7:0] m_snap;
  logic       m_rdq, m_hold;

  always #2.5 clk = ~clk;

  evt_irq_status i_evt_irq_status (
    .clk(clk), .rst_n(rst_n),
    .evt_periodic(ev[2]), .evt_alarm(ev[1]), .evt_update(ev[0]),
    .cfg_wr(wr), .cfg_set(set_b), .cfg_pie(pie), .cfg_aie(aie), .cfg_uie(uie),
    .rd_strobe(st), .rd_sel(sel), .rd_data(rd_data),
    .irq_o(irq_o), .irq_oe(irq_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_irq();
    return |(m_flag & m_en);
  endfunction

  task automatic model_edge();
    logic rise, capture, fall, irqf_old;
    rise     = st & ~m_rdq;
    capture  = rise & ~sel;
    fall     = ~st & m_hold;
    irqf_old = exp_irq();
    if (rise) m_snap = sel ? 8'h80 : {irqf_old, m_flag, 4'b0000};
    if (fall) begin
      m_flag = m_pend | ev;
      m_pend = 3'b000;
    end else if (capture || m_hold) m_pend = m_pend | ev;
    else m_flag = m_flag | ev;
    if (wr) m_en = {pie, aie, uie & ~set_b};
    if (capture) m_hold = 1'b1;
    else if (!st) m_hold = 1'b0;
    m_rdq = st;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R3 irq_oe", {7'd0, irq_oe}, {7'd0, exp_irq()});
    chk("R3 irq_o",  {7'd0, irq_o}, 8'd0);
    chk("R5 rd_data", rd_data, m_snap);
    ev = 3'b000;
    wr = 1'b0;
  endtask

  task automatic cfg(input logic s, input logic p, input logic a, input logic u);
    wr = 1'b1; set_b = s; pie = p; aie = a; uie = u;
    cyc();
  endtask

  task automatic do_read(input logic rsel, input int len, output logic [7:0] got);
    st = 1'b1; sel = rsel;
    cyc();
    got = rd_data;
    for (int i = 1; i < len; i++) cyc();
    st = 1'b0;
    cyc();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] got;
    void'($urandom(32'd4242));
    rst_n = 1'b0; ev = '0; wr = 0; set_b = 0; pie = 0; aie = 0; uie = 0; st = 0; sel = 0;
    m_flag = '0; m_pend = '0; m_en = '0; m_snap = '0; m_rdq = 0; m_hold = 0;
    repeat (4) @(negedge clk);
    chk("R1 irq_oe", {7'd0, irq_oe}, 8'd0);
    chk("R1 rd_data", rd_data, 8'd0);
    rst_n = 1'b1;
    cyc();

    // R2: flag without enable
    ev = 3'b010; cyc();
    chk("R2 irq masked", {7'd0, irq_oe}, 8'd0);
    do_read(1'b0, 2, got);
    chk("R2 R4 alarm flag byte", got, 8'h20);
    do_read(1'b0, 1, got);
    chk("R6 cleared", got, 8'h00);

    // R3/R4 enabled periodic
    cfg(0, 1, 0, 0);
    ev = 3'b100; cyc();
    chk("R3 irq set", {7'd0, irq_oe}, 8'd1);
    do_read(1'b0, 3, got);
    chk("R4 byte with summary", got, 8'hC0);
    chk("R6 irq released", {7'd0, irq_oe}, 8'd0);

    // R3: enable after flag
    ev = 3'b001; cyc();
    chk("R3 no irq yet", {7'd0, irq_oe}, 8'd0);
    cfg(0, 1, 0, 1);
    chk("R3 late enable", {7'd0, irq_oe}, 8'd1);
    cfg(1, 1, 0, 1);
    chk("R8 set kills uie", {7'd0, irq_oe}, 8'd0);
    do_read(1'b0, 1, got);
    chk("R8 flag kept", got, 8'h10);

    // R5/R7: event during read
    cfg(0, 0, 1, 0);
    st = 1'b1; sel = 1'b0; cyc();
    ev = 3'b010; cyc();
    chk("R5 data held", rd_data, 8'h00);
    chk("R5 irq held", {7'd0, irq_oe}, 8'd0);
    st = 1'b0; cyc();
    chk("R7 posted", {7'd0, irq_oe}, 8'd1);
    do_read(1'b0, 1, got);
    chk("R7 posted byte", got, 8'hA0);

    // R7: event in the fall cycle; R9: valid read leaves flags
    st = 1'b1; cyc();
    st = 1'b0; ev = 3'b100; cyc();
    do_read(1'b1, 2, got);
    chk("R9 valid byte", got, 8'h80);
    do_read(1'b0, 1, got);
    chk("R9 R7 flag survives", got, 8'h40);
    st = 1'b1; sel = 1'b1; cyc();
    ev = 3'b001; cyc();
    st = 1'b0; cyc();
    do_read(1'b0, 1, got);
    chk("R9 event not deferred", got, 8'h10);

    // random phase
    begin
      int rd_left = 0;
      for (int n = 0; n < 4000; n++) begin
        ev = {($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0};
        if (($urandom % 16) == 0) begin
          wr = 1'b1; set_b = ($urandom % 4) == 0;
          pie = $urandom; aie = $urandom; uie = $urandom;
        end
        if (rd_left > 0) begin
          rd_left--;
          if (rd_left == 0) st = 1'b0;
        end else if (!st && ($urandom % 6) == 0) begin
          st = 1'b1; sel = ($urandom % 4) == 0;
          rd_left = 1 + ($urandom % 4);
        end
        cyc();
      end
      st = 1'b0;
      cyc();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule